// File: doc/BRIEF.md
# Supply Detection and Heavy-Load Guard

This block controls a supply-voltage comparator and a heavy-load protection mode. Software switches the detector on through a control register. The detector draws current while it is on, so software normally leaves it off. Once the detector is switched on, the block waits for a settling interval and only then marks the comparison result as valid. A valid "supply low" result, or a software request, puts the chip into protection mode.

In protection mode, a heavy-load drive permit is granted only after an entry delay. The system reports when heavy driving is in progress. Once driving ends, a long hold period must pass before software may release protection mode. A release request that comes too early is ignored and sets a sticky error flag.

All delays are counted from an external tick pulse. The tick period is a parameter, and each delay's tick count is derived from it when the design is elaborated. The analog comparator sits outside the block and supplies a single level.

Top module: `supply_guard`

## Requirements
- R1: After reset, det_on, det_valid, det_low, prot_mode, drive_ok and cancel_err are all 0.
- R2: A write to address 0 loads wr_data[0] into the detector enable, which is seen on det_on. Writing 1 turns the detector on and writing 0 turns it off.
- R3: det_valid rises once SETTLE = ceil(100/TICK_US)+1 ticks have been seen with the detector enabled. It stays 0 after SETTLE-1 ticks.
- R4: det_valid drops in the same cycle that det_on drops. A new enable starts the settling count again from zero.
- R5: cmp_low is synchronized through two flops. det_low is 1 only while det_valid is 1 and the synchronized comparator level is 1. While det_low is 1, protection mode is entered. A high comparator level while the result is not valid has no effect.
- R6: A write to address 1 with wr_data[0]=1 enters protection mode (prot_mode=1) on the next clock when the block is out of protection.
- R7: drive_ok is 0 until ENTRY = ceil(1000/TICK_US)+1 ticks have passed in protection mode, and is then 1. It is never 1 outside protection mode.
- R8: Protection mode can be released by a write to address 1 with wr_data[1]=1. The release is accepted only once HOLD = ceil(2000000/TICK_US)+1 ticks have passed since drive_busy last fell. An accepted release clears prot_mode and drive_ok.
- R9: A release request made inside protection mode before the hold expires is ignored and sets cancel_err. Writing address 1 with wr_data[2]=1 clears cancel_err. If a new error and a clear happen in the same write, the error is kept.
- R10: If drive_busy rises during the hold period, the hold period restarts when drive_busy falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle timebase pulse, one every TICK_US microseconds |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register address: 0 is control, 1 is command |
| wr_data | input | 3 | Write data: control bit0 = enable; command bit0 = protect, bit1 = release, bit2 = clear error |
| cmp_low | input | 1 | Comparator output, 1 when the supply is at or below the threshold |
| drive_busy | input | 1 | 1 while heavy-load driving is in progress |
| det_on | output | 1 | Detector enable |
| det_valid | output | 1 | Settled comparison result is valid |
| det_low | output | 1 | Valid low-supply result |
| prot_mode | output | 1 | Protection mode active |
| drive_ok | output | 1 | Heavy-load drive permit |
| cancel_err | output | 1 | Sticky premature-release error |

## Verification
The hardest case to reach is the restarted hold period. A release request has to be placed where a hold that had not been restarted would already have expired, while a correctly restarted hold still has not. The stimulus first lets the hold run for 100 ticks. It then raises and drops drive_busy again, waits HOLD-50 ticks, and issues a release that must be refused. It then waits 50 more ticks and issues a release that must be accepted. Separate one-tick-short probes cover the settling and entry boundaries.

// File: rtl/sg_pkg.sv
// Package for the supply guard: register addresses, controller states and
// a helper that turns a time in microseconds into a tick count.
package sg_pkg;

    localparam int ADDR_W = 1;
    localparam int DATA_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 1'b0;
    localparam logic [ADDR_W-1:0] ADDR_CMD  = 1'b1;

    // Bit positions inside the command register.
    localparam int CMD_PROTECT = 0;
    localparam int CMD_RELEASE = 1;
    localparam int CMD_CLRERR  = 2;

    typedef enum logic [2:0] {
        PG_OFF   = 3'd0,
        PG_ENTRY = 3'd1,
        PG_READY = 3'd2,
        PG_DRIVE = 3'd3,
        PG_HOLD  = 3'd4,
        PG_FREE  = 3'd5
    } pg_state_t;

    // Ceiling division. The extra tick added by callers covers the unknown
    // phase of the first tick.
    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/sg_tick_timer.sv
// Saturating tick counter. It counts tick pulses while run is high and
// holds at LIMIT. Assumes LIMIT >= 1. Clear has priority over counting.
module sg_tick_timer #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Count ticks up to the limit, restarting on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt <= '0;
        end else if (run && tick && cnt != CW'(LIMIT)) begin
            cnt <= cnt + CW'(1);
        end
    end

    // The limit has been reached.
    always_comb done = (cnt == CW'(LIMIT));

endmodule

// File: rtl/sg_regs.sv
// Register decoder. The control register holds the detector enable. The
// command register produces one-cycle pulses: protect, release and
// clear-error. Writes take effect on the clock edge of the strobe.
module sg_regs
    import sg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              det_en,
    output logic              req_protect,
    output logic              req_release,
    output logic              req_clrerr
);
    logic cmd_hit;

    // Decode a command-register write.
    always_comb cmd_hit = wr_en && (wr_addr == ADDR_CMD);

    // Hold the detector enable level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            det_en <= 1'b0;
        end else if (wr_en && wr_addr == ADDR_CTRL) begin
            det_en <= wr_data[0];
        end
    end

    // Turn command bits into combinational pulses.
    always_comb begin
        req_protect = cmd_hit && wr_data[CMD_PROTECT];
        req_release = cmd_hit && wr_data[CMD_RELEASE];
        req_clrerr  = cmd_hit && wr_data[CMD_CLRERR];
    end

endmodule

// File: rtl/sg_detector.sv
// Detector front end. It synchronizes the comparator level, waits
// SETTLE_TICKS ticks after enable, and then reports a valid result.
// Assumes cmp_in is asynchronous to clk.
module sg_detector #(
    parameter int unsigned SETTLE_TICKS = 2,
    parameter int          SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_en,
    input  logic tick,
    input  logic cmp_in,
    output logic valid,
    output logic low
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   settled;

    // Shift the comparator level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], cmp_in};
        end
    end

    sg_tick_timer #(.LIMIT(SETTLE_TICKS)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (!det_en),
        .run   (det_en),
        .tick  (tick),
        .done  (settled)
    );

    // Combine enable, settling and the synchronized level.
    always_comb begin
        valid = det_en && settled;
        low   = valid && sync_q[SYNC_STAGES-1];
    end

endmodule

// File: rtl/sg_protect.sv
// Protection-mode sequencer. It enters on a request, grants the drive permit
// after the entry delay, and tracks heavy driving. Release is allowed only
// after the hold period following the end of driving. Early releases set a
// sticky error.
module sg_protect
    import sg_pkg::*;
#(
    parameter int unsigned ENTRY_TICKS = 11,
    parameter int unsigned HOLD_TICKS  = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic enter_req,
    input  logic release_req,
    input  logic clrerr_req,
    input  logic busy,
    output logic prot,
    output logic permit,
    output logic err
);
    pg_state_t state, state_nx;
    logic      entry_done, hold_done, early;

    sg_tick_timer #(.LIMIT(ENTRY_TICKS)) u_entry (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state != PG_ENTRY),
        .run   (state == PG_ENTRY),
        .tick  (tick),
        .done  (entry_done)
    );

    sg_tick_timer #(.LIMIT(HOLD_TICKS)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state != PG_HOLD),
        .run   (state == PG_HOLD),
        .tick  (tick),
        .done  (hold_done)
    );

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            PG_OFF:   if (enter_req) state_nx = PG_ENTRY;
            PG_ENTRY: if (entry_done) state_nx = PG_READY;
            PG_READY: if (busy) state_nx = PG_DRIVE;
            PG_DRIVE: if (!busy) state_nx = PG_HOLD;
            PG_HOLD: begin
                if (busy) state_nx = PG_DRIVE;
                else if (hold_done) state_nx = PG_FREE;
            end
            PG_FREE: begin
                if (busy) state_nx = PG_DRIVE;
                else if (release_req) state_nx = PG_OFF;
            end
            default: state_nx = PG_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PG_OFF;
        else        state <= state_nx;
    end

    // A release is early anywhere in protection except the free state.
    always_comb early = release_req && (state != PG_OFF) && (state != PG_FREE);

    // Sticky error: a new error wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)          err <= 1'b0;
        else if (early)      err <= 1'b1;
        else if (clrerr_req) err <= 1'b0;
    end

    // Status decode.
    always_comb begin
        prot   = (state != PG_OFF);
        permit = (state != PG_OFF) && (state != PG_ENTRY);
    end

endmodule

// File: rtl/supply_guard.sv
// Top of the supply guard. It wires the register decoder, the detector
// front end and the protection sequencer. The tick input must be a
// one-cycle pulse every TICK_US microseconds. Delay tick counts are derived
// at elaboration.
module supply_guard
    import sg_pkg::*;
#(
    parameter int unsigned TICK_US   = 50,
    parameter int unsigned SETTLE_US = 100,
    parameter int unsigned ENTRY_US  = 1000,
    parameter int unsigned HOLD_US   = 2000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cmp_low,
    input  logic              drive_busy,
    output logic              det_on,
    output logic              det_valid,
    output logic              det_low,
    output logic              prot_mode,
    output logic              drive_ok,
    output logic              cancel_err
);
    localparam int unsigned SETTLE_TICKS = ceil_div(SETTLE_US, TICK_US) + 1;
    localparam int unsigned ENTRY_TICKS  = ceil_div(ENTRY_US, TICK_US) + 1;
    localparam int unsigned HOLD_TICKS   = ceil_div(HOLD_US, TICK_US) + 1;

    logic req_protect, req_release, req_clrerr;

    sg_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .det_en      (det_on),
        .req_protect (req_protect),
        .req_release (req_release),
        .req_clrerr  (req_clrerr)
    );

    sg_detector #(.SETTLE_TICKS(SETTLE_TICKS), .SYNC_STAGES(2)) u_det (
        .clk    (clk),
        .rst_n  (rst_n),
        .det_en (det_on),
        .tick   (tick),
        .cmp_in (cmp_low),
        .valid  (det_valid),
        .low    (det_low)
    );

    sg_protect #(.ENTRY_TICKS(ENTRY_TICKS), .HOLD_TICKS(HOLD_TICKS)) u_prot (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .enter_req   (req_protect || det_low),
        .release_req (req_release),
        .clrerr_req  (req_clrerr),
        .busy        (drive_busy),
        .prot        (prot_mode),
        .permit      (drive_ok),
        .err         (cancel_err)
    );

endmodule

// File: rtl/supply_guard_chk.sv
// Property checker for supply_guard. It observes the top-level ports only
// and is attached through bind.
module supply_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [0:0] wr_addr,
    input logic [2:0] wr_data,
    input logic       det_on,
    input logic       det_valid,
    input logic       det_low,
    input logic       prot_mode,
    input logic       drive_ok,
    input logic       cancel_err
);
    assert_valid_needs_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        det_valid |-> det_on);

    assert_valid_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(det_on) |-> !det_valid);

    assert_low_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        det_low |-> det_valid);

    assert_low_enters_R5: assert property (@(posedge clk) disable iff (!rst_n)
        det_low |=> prot_mode);

    assert_sw_enters_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 1'b1 && wr_data[0]) |=> prot_mode);

    assert_permit_in_prot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        drive_ok |-> prot_mode);

    assert_permit_late_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_ok) |-> $past(prot_mode));

    assert_exit_from_permit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_mode) |-> $past(drive_ok));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel_err && !(wr_en && wr_addr == 1'b1 && wr_data[2])) |=> cancel_err);

endmodule

bind supply_guard supply_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .det_on     (det_on),
    .det_valid  (det_valid),
    .det_low    (det_low),
    .prot_mode  (prot_mode),
    .drive_ok   (drive_ok),
    .cancel_err (cancel_err)
);

// File: tb/supply_guard_test.sv
// Directed bench for supply_guard. Each scenario task checks its own results.
module supply_guard_test;
    localparam int TICK_US = 100;
    localparam int SETTLE  = (100 + TICK_US - 1) / TICK_US + 1;
    localparam int ENTRY   = (1000 + TICK_US - 1) / TICK_US + 1;
    localparam int HOLD    = (2000000 + TICK_US - 1) / TICK_US + 1;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [0:0] wr_addr = 1'b0;
    logic [2:0] wr_data = 3'b000;
    logic       cmp_low = 1'b0;
    logic       drive_busy = 1'b0;
    logic       det_on, det_valid, det_low, prot_mode, drive_ok, cancel_err;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    supply_guard #(.TICK_US(TICK_US)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .cmp_low(cmp_low),
        .drive_busy(drive_busy), .det_on(det_on), .det_valid(det_valid),
        .det_low(det_low), .prot_mode(prot_mode), .drive_ok(drive_ok),
        .cancel_err(cancel_err)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic write(input logic a, input logic [2:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 3'b000;
        idle(1);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmp_low = 1'b0; drive_busy = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 det_on", det_on, 1'b0);
        check("R1 det_valid", det_valid, 1'b0);
        check("R1 det_low", det_low, 1'b0);
        check("R1 prot_mode", prot_mode, 1'b0);
        check("R1 drive_ok", drive_ok, 1'b0);
        check("R1 cancel_err", cancel_err, 1'b0);
    endtask

    task automatic t_settle();
        do_reset();
        write(1'b0, 3'b001);
        check("R2 enable", det_on, 1'b1);
        cmp_low = 1'b1;
        ticks(SETTLE - 1); idle(2);
        check("R3 not yet valid", det_valid, 1'b0);
        check("R5 ignored before valid", prot_mode, 1'b0);
        cmp_low = 1'b0;
        ticks(1); idle(2);
        check("R3 valid", det_valid, 1'b1);
        check("R5 low clear", det_low, 1'b0);
        write(1'b0, 3'b000);
        check("R2 disable", det_on, 1'b0);
        check("R4 valid dropped", det_valid, 1'b0);
        write(1'b0, 3'b001);
        ticks(SETTLE - 1); idle(2);
        check("R4 restart count", det_valid, 1'b0);
        ticks(1); idle(2);
        check("R4 valid again", det_valid, 1'b1);
    endtask

    task automatic t_low_entry();
        do_reset();
        write(1'b0, 3'b001);
        ticks(SETTLE); idle(2);
        cmp_low = 1'b1;
        idle(4);
        check("R5 det_low", det_low, 1'b1);
        check("R5 protection", prot_mode, 1'b1);
        check("R7 no permit yet", drive_ok, 1'b0);
    endtask

    task automatic t_entry_and_hold();
        do_reset();
        write(1'b1, 3'b001);
        check("R6 sw entry", prot_mode, 1'b1);
        drive_busy = 1'b1;
        ticks(ENTRY - 1); idle(2);
        check("R7 permit early", drive_ok, 1'b0);
        drive_busy = 1'b0;
        ticks(1); idle(2);
        check("R7 permit granted", drive_ok, 1'b1);
        drive_busy = 1'b1; idle(3);
        drive_busy = 1'b0; idle(2);
        ticks(100);
        write(1'b1, 3'b010);
        check("R9 early release err", cancel_err, 1'b1);
        check("R9 early release ignored", prot_mode, 1'b1);
        write(1'b1, 3'b110);
        check("R9 set beats clear", cancel_err, 1'b1);
        write(1'b1, 3'b100);
        check("R9 cleared", cancel_err, 1'b0);
        drive_busy = 1'b1; idle(3);
        drive_busy = 1'b0; idle(2);
        ticks(HOLD - 50); idle(2);
        write(1'b1, 3'b010);
        check("R10 hold restarted", prot_mode, 1'b1);
        check("R10 err on early", cancel_err, 1'b1);
        write(1'b1, 3'b100);
        ticks(50); idle(2);
        write(1'b1, 3'b010);
        check("R8 release prot", prot_mode, 1'b0);
        check("R8 release permit", drive_ok, 1'b0);
        check("R8 no err", cancel_err, 1'b0);
    endtask

    initial begin
        t_reset();
        t_settle();
        t_low_entry();
        t_entry_and_hold();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule